// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block produces the row strobe, column strobe, row/column address-select and data-acknowledge for a DRAM controller that keeps a row open between accesses. Each access is requested by a one-cycle address strobe, carrying an address and a read/write flag. If the new access falls in the row that is already open, the row strobe stays asserted. Only the column strobe and the acknowledge pulse for that access. If the access falls in a different row, the block closes the row and waits out a programmed precharge. It then replays the request as an opening access.

The page-hit decision has two sources. It can come from an internal comparison of the upper address bits against the open row. It can also come from an external page-change input, sampled together with the strobe. Two small programming inputs set the acknowledge delay and the precharge length. A strobe that arrives while the sequencer is busy is held in a single-entry slot and is serviced when the sequencer returns to idle or to the row-open state.

Top module: `dram_page_seq`

## Requirements
- R1: Synchronous active-low reset drives `ras`, `cas`, `col_sel` and `ack` low and leaves no row open, so the first access after reset is always an opening access.
- R2: An opening access raises `ras` with `col_sel` low in the cycle after the edge that samples the strobe. The column phase starts on the next cycle.
- R3: A read that hits the open row raises `cas` (with `col_sel` high) in the cycle after the edge that samples the strobe, and `ras` stays high throughout.
- R4: A write starts `cas` one clock later than a read would in the same situation. During the extra cycle `ras` and `col_sel` are high and `cas` is low.
- R5: `ack_dly` (0 to 3) sets how many cycles after the first `cas` cycle `ack` rises. `cas` stays high until then.
- R6: `ack` is high for a single cycle, and `cas` and `ack` fall on the same edge while `ras` stays high.
- R7: With the internal comparator selected, an access whose row bits `addr[15:8]` differ from the open row is a miss. `ras` goes low for exactly `pre_len`+1 cycles, and then the access is replayed as an opening access.
- R8: With `ext_cmp_en` high, `page_change`=1 sampled with the strobe forces a miss and `page_change`=0 forces a hit, whatever the row bits are.
- R9: A strobe that arrives during a row, column or precharge phase is held and serviced one cycle after the sequencer returns to the row-open state.
- R10: `cas` is never high while `ras` is low, and `col_sel` is low during the first cycle of every `ras` assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | One-cycle access request |
| addr | input | 16 | Access address; upper 8 bits are the row |
| wr | input | 1 | 1 = write, 0 = read |
| ext_cmp_en | input | 1 | 1 = page decision from `page_change` |
| page_change | input | 1 | External page-change flag, sampled with the strobe |
| ack_dly | input | 2 | Extra acknowledge delay, in cycles |
| pre_len | input | 2 | Precharge length minus one, in cycles |
| ras | output | 1 | Row strobe, active high |
| cas | output | 1 | Column strobe, active high |
| col_sel | output | 1 | Address-mux select: 0 = row, 1 = column |
| ack | output | 1 | Data acknowledge, active high |

## Verification
Some rules hold on every cycle, and the assertions check those continuously: `cas` only inside `ras`, `ack` only inside `cas`, `cas` and `ack` ending on the same edge, a row phase before any column phase, and a minimum precharge between a fall and a rise of `ras`. Other behaviour depends on what was requested, and only the directed scenarios can show it. That covers whether an access was a hit or a miss, the read/write difference of one clock, the exact acknowledge delay, the replay after precharge, the service of a held strobe, and the absence of an open row after reset.

// File: rtl/dram_pg_pkg.sv
// Package: shared state encoding for the page-mode sequencer.
// Assumes: nothing; pure type definitions.
package dram_pg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // no row open
        ST_ROW  = 3'd1,   // row strobe just asserted, row address on mux
        ST_CASW = 3'd2,   // write: column address out, strobe held back one clock
        ST_CAS  = 3'd3,   // column strobe active, counting acknowledge delay
        ST_OPEN = 3'd4,   // row open, waiting for next access
        ST_PRE  = 3'd5    // row closed, precharge running
    } seq_state_t;

endpackage

// File: rtl/dram_pg_hold.sv
// Module: dram_pg_hold
// Single-entry holding slot for an access strobe that arrives while the
// sequencer cannot accept it. A capture in the same cycle as a take
// wins, so a back-to-back strobe is never lost.
// Assumes: at most one outstanding request; a newer capture overwrites.
module dram_pg_hold #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic              cap_wr,
    input  logic              cap_pc,
    input  logic              take,
    output logic              vld,
    output logic [ADDR_W-1:0] h_addr,
    output logic              h_wr,
    output logic              h_pc
);

    // Purpose: load the slot on capture, clear it when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= 1'b0;
            h_addr <= '0;
            h_wr   <= 1'b0;
            h_pc   <= 1'b0;
        end else if (cap) begin
            vld    <= 1'b1;
            h_addr <= cap_addr;
            h_wr   <= cap_wr;
            h_pc   <= cap_pc;
        end else if (take) begin
            vld    <= 1'b0;
        end
    end

endmodule

// File: rtl/dram_pg_cmp.sv
// Module: dram_pg_cmp
// Tracks the open row and decides page hit. In internal mode the new row
// bits are compared with the stored row; in external mode the sampled
// page-change flag decides. With no row open every access misses.
// Assumes: open_load and close are never asserted together.
module dram_pg_cmp #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_load,
    input  logic [ROW_W-1:0] open_row_in,
    input  logic             close,
    input  logic [ROW_W-1:0] new_row,
    input  logic             ext_mode,
    input  logic             ext_change,
    output logic             row_open,
    output logic             hit
);

    logic [ROW_W-1:0] open_row;

    // Purpose: remember which row is open and whether any is.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            open_row <= '0;
        end else if (open_load) begin
            row_open <= 1'b1;
            open_row <= open_row_in;
        end else if (close) begin
            row_open <= 1'b0;
        end
    end

    // Purpose: select the hit source.
    always_comb begin
        if (ext_mode) hit = row_open && !ext_change;
        else          hit = row_open && (new_row == open_row);
    end

endmodule

// File: rtl/dram_pg_dcnt.sv
// Module: dram_pg_dcnt
// Loadable down-counter that stops at zero; used for the acknowledge
// delay and for the precharge length.
// Assumes: load is pulsed on entry to the phase being timed.
module dram_pg_dcnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Purpose: load a start value, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/dram_page_seq.sv
// Module: dram_page_seq (top)
// Page-mode DRAM strobe sequencer. Keeps the row open across hits,
// toggles only the column strobe and acknowledge per access, closes
// the row and enforces precharge on a miss, then replays the missed
// access as an opening access. Busy-time strobes are held in one slot.
// Assumes: strobe is a single-cycle pulse; row = upper ROW_W address bits;
// ack_dly and pre_len stay stable during an access.
module dram_page_seq #(
    parameter int ADDR_W = 16,
    parameter int ROW_W  = 8,
    parameter int DLY_W  = 2,
    parameter int PRE_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [ADDR_W-1:0] addr,
    input  logic             wr,
    input  logic             ext_cmp_en,
    input  logic             page_change,
    input  logic [DLY_W-1:0] ack_dly,
    input  logic [PRE_W-1:0] pre_len,
    output logic             ras,
    output logic             cas,
    output logic             col_sel,
    output logic             ack
);
    import dram_pg_pkg::*;

    localparam int ROW_LSB = ADDR_W - ROW_W;

    seq_state_t state, nxt;

    logic              can_accept, req_v, take, cap;
    logic              h_vld, h_wr, h_pc;
    logic [ADDR_W-1:0] h_addr;
    logic [ADDR_W-1:0] req_addr;
    logic              req_wr, req_pc;
    logic [ROW_W-1:0]  req_row, cur_row, row_to_open;
    logic              cur_wr;
    logic              hit, row_open;
    logic              ack_zero, pre_zero;
    logic              ack_load, pre_load, open_load;

    // Purpose: decide whether a request can start now and where it comes from.
    always_comb begin
        can_accept = (state == ST_IDLE) || (state == ST_OPEN);
        take       = can_accept && h_vld;
        req_v      = can_accept && (h_vld || strobe);
        cap        = strobe && !(can_accept && !h_vld);
        req_addr   = h_vld ? h_addr : addr;
        req_wr     = h_vld ? h_wr   : wr;
        req_pc     = h_vld ? h_pc   : page_change;
        req_row    = req_addr[ADDR_W-1:ROW_LSB];
    end

    dram_pg_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (cap),
        .cap_addr (addr),
        .cap_wr   (wr),
        .cap_pc   (page_change),
        .take     (take),
        .vld      (h_vld),
        .h_addr   (h_addr),
        .h_wr     (h_wr),
        .h_pc     (h_pc)
    );

    // Purpose: latch the row and direction of the access being serviced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row <= '0;
            cur_wr  <= 1'b0;
        end else if (req_v) begin
            cur_row <= req_row;
            cur_wr  <= req_wr;
        end
    end

    // Purpose: next-state logic of the access sequence.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_v) nxt = ST_ROW;
            ST_OPEN: if (req_v) begin
                if (hit) nxt = req_wr ? ST_CASW : ST_CAS;
                else     nxt = ST_PRE;
            end
            ST_ROW:  nxt = cur_wr ? ST_CASW : ST_CAS;
            ST_CASW: nxt = ST_CAS;
            ST_CAS:  if (ack_zero) nxt = ST_OPEN;
            ST_PRE:  if (pre_zero) nxt = ST_ROW;
            default: nxt = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Purpose: pulses that start the timers and update the open-row record.
    always_comb begin
        ack_load    = (nxt == ST_CAS) && (state != ST_CAS);
        pre_load    = (nxt == ST_PRE) && (state != ST_PRE);
        open_load   = (nxt == ST_ROW) && (state != ST_ROW);
        row_to_open = (state == ST_PRE) ? cur_row : req_row;
    end

    dram_pg_cmp #(.ROW_W(ROW_W)) u_cmp (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_load   (open_load),
        .open_row_in (row_to_open),
        .close       (pre_load),
        .new_row     (req_row),
        .ext_mode    (ext_cmp_en),
        .ext_change  (req_pc),
        .row_open    (row_open),
        .hit         (hit)
    );

    dram_pg_dcnt #(.W(DLY_W)) u_ack_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ack_load),
        .val   (ack_dly),
        .zero  (ack_zero)
    );

    dram_pg_dcnt #(.W(PRE_W)) u_pre_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pre_load),
        .val   (pre_len),
        .zero  (pre_zero)
    );

    // Purpose: decode the strobes from the state register.
    always_comb begin
        ras     = (state == ST_ROW) || (state == ST_CASW) ||
                  (state == ST_CAS) || (state == ST_OPEN);
        cas     = (state == ST_CAS);
        col_sel = (state == ST_CASW) || (state == ST_CAS) || (state == ST_OPEN);
        ack     = (state == ST_CAS) && ack_zero;
    end

endmodule

// File: rtl/dram_page_seq_chk.sv
// Module: dram_page_seq_chk
// Property checker bound to dram_page_seq; watches only its ports.
// Assumes: pre_len is stable from the fall of ras to its next rise.
module dram_page_seq_chk #(
    parameter int PRE_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras,
    input logic             cas,
    input logic             col_sel,
    input logic             ack,
    input logic [PRE_W-1:0] pre_len
);

    logic             ras_q, seen_fall;
    logic [PRE_W+1:0] low_cnt;
    logic [PRE_W-1:0] pl_q;

    // Purpose: measure how long ras stays low after each fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q     <= 1'b0;
            seen_fall <= 1'b0;
            low_cnt   <= '0;
            pl_q      <= '0;
        end else begin
            ras_q <= ras;
            if (ras)                low_cnt <= '0;
            else if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
            if (ras_q && !ras) begin
                seen_fall <= 1'b1;
                pl_q      <= pre_len;
            end
        end
    end

    assert_cas_in_ras_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cas |-> ras);

    assert_row_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ras && !ras_q) |-> (!col_sel && !cas));

    assert_ack_in_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> cas);

    assert_end_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!ack && !cas && ras));

    assert_no_lone_cas_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cas && !ack) |=> cas);

    assert_precharge_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ras && !ras_q && seen_fall) |->
            (low_cnt == ({2'b00, pl_q} + 1'b1)));

endmodule

bind dram_page_seq dram_page_seq_chk #(.PRE_W(PRE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ras     (ras),
    .cas     (cas),
    .col_sel (col_sel),
    .ack     (ack),
    .pre_len (pre_len)
);

// File: tb/dram_page_seq_test.sv
// Directed bench for dram_page_seq. Inputs change on the falling edge and
// outputs are sampled on the falling edge; obs = {ras, cas, col_sel, ack}.
module dram_page_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [15:0] addr = '0;
    logic        wr = 1'b0;
    logic        ext_cmp_en = 1'b0;
    logic        page_change = 1'b0;
    logic [1:0]  ack_dly = '0;
    logic [1:0]  pre_len = '0;
    logic        ras, cas, col_sel, ack;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_page_seq uut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .addr(addr), .wr(wr),
        .ext_cmp_en(ext_cmp_en), .page_change(page_change),
        .ack_dly(ack_dly), .pre_len(pre_len),
        .ras(ras), .cas(cas), .col_sel(col_sel), .ack(ack)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic expect_obs(string req, logic [3:0] exp);
        logic [3:0] act;
        act = {ras, cas, col_sel, ack};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: {ras,cas,col_sel,ack} actual=%b expected=%b at %0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic issue(logic [15:0] a, logic w, logic pc);
        strobe = 1'b1; addr = a; wr = w; page_change = pc;
        tick();
        strobe = 1'b0; page_change = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_reset();
        do_reset();
        expect_obs("R1 reset state", 4'b0000);
    endtask

    task automatic t_open_read();
        ack_dly = 2'd0;
        issue(16'h1200, 1'b0, 1'b0);
        expect_obs("R2 opening row phase", 4'b1000);
        tick(); expect_obs("R2 column phase ack_dly=0 R5", 4'b1111);
        tick(); expect_obs("R6 cas/ack end, row held", 4'b1010);
    endtask

    task automatic t_hit_read();
        ack_dly = 2'd2;
        issue(16'h1234, 1'b0, 1'b0);
        expect_obs("R3 hit read cas at once", 4'b1110);
        tick(); expect_obs("R5 delay cycle", 4'b1110);
        tick(); expect_obs("R5 ack after 2", 4'b1111);
        tick(); expect_obs("R6 end together", 4'b1010);
    endtask

    task automatic t_hit_write();
        ack_dly = 2'd0;
        issue(16'h12ff, 1'b1, 1'b0);
        expect_obs("R4 write cas held back", 4'b1010);
        tick(); expect_obs("R4 write cas one later", 4'b1111);
        tick(); expect_obs("R6 write end", 4'b1010);
    endtask

    task automatic t_miss();
        pre_len = 2'd2; ack_dly = 2'd0;
        issue(16'h3400, 1'b0, 1'b0);
        expect_obs("R7 miss closes row", 4'b0000);
        tick(); expect_obs("R7 precharge 2", 4'b0000);
        tick(); expect_obs("R7 precharge 3", 4'b0000);
        tick(); expect_obs("R7 replay row phase R10", 4'b1000);
        tick(); expect_obs("R7 replay column", 4'b1111);
        tick(); expect_obs("R7 row held after replay", 4'b1010);
    endtask

    task automatic t_pre_min();
        pre_len = 2'd0;
        issue(16'h5600, 1'b1, 1'b0);
        expect_obs("R7 one-cycle precharge", 4'b0000);
        tick(); expect_obs("R7 reopen after 1", 4'b1000);
        tick(); expect_obs("R4 write after reopen", 4'b1010);
        tick(); expect_obs("R4 write cas", 4'b1111);
        tick(); expect_obs("R6 end", 4'b1010);
    endtask

    task automatic t_ext();
        ext_cmp_en = 1'b1; pre_len = 2'd0; ack_dly = 2'd0;
        issue(16'h7700, 1'b0, 1'b0);
        expect_obs("R8 other row, no change = hit", 4'b1111);
        tick(); expect_obs("R8 hit end", 4'b1010);
        issue(16'h5600, 1'b0, 1'b1);
        expect_obs("R8 same row, change = miss", 4'b0000);
        tick(); expect_obs("R8 reopen", 4'b1000);
        tick(); expect_obs("R8 column", 4'b1111);
        tick(); expect_obs("R8 end", 4'b1010);
        ext_cmp_en = 1'b0;
    endtask

    task automatic t_pending();
        ack_dly = 2'd3;
        issue(16'h5611, 1'b0, 1'b0);
        expect_obs("R9 first access cas", 4'b1110);
        issue(16'h5622, 1'b1, 1'b0);
        expect_obs("R9 busy strobe, cas held", 4'b1110);
        tick(); expect_obs("R9 delay", 4'b1110);
        tick(); expect_obs("R9 first ack", 4'b1111);
        tick(); expect_obs("R9 return to open", 4'b1010);
        tick(); expect_obs("R9 held write starts", 4'b1010);
        tick(); expect_obs("R9 held write cas", 4'b1110);
        tick(); tick(); tick();
        expect_obs("R9 held write ack", 4'b1111);
        tick(); expect_obs("R9 held write end", 4'b1010);
    endtask

    task automatic t_reset_mid();
        do_reset();
        expect_obs("R1 reset closes row", 4'b0000);
        ack_dly = 2'd0;
        issue(16'h5600, 1'b0, 1'b0);
        expect_obs("R1 no row open after reset", 4'b1000);
        tick(); expect_obs("R1 opening column", 4'b1111);
        tick();
    endtask

    initial begin
        tick();
        t_reset();
        t_open_read();
        t_hit_read();
        t_hit_write();
        t_miss();
        t_pre_min();
        t_ext();
        t_pending();
        t_reset_mid();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule